// File: doc/BRIEF.md
# Turbo Rapid Fire Modulator

This block sits between the eight button contacts of a gamepad and the parallel-load inputs of its report shift register. Each button has its own turbo-enable bit. A button with turbo off passes straight through. A button with turbo on is ANDed with a free-running square wave, so that holding it produces alternating pressed and released levels.

The square wave comes from a divider running on the system clock. A configuration word sets its half-period in clock cycles. The block clamps that word so that the toggle rate stays between 15 and 30 Hz for the clock frequency given as a parameter. The divider has no input from the host's latch or shift signals. The toggle phase therefore depends only on elapsed time, and two polls in quick succession see the same levels. The serial report that follows keeps the standard bit order and read sequence, because this block only changes the levels that get loaded.

Top module: `turbo_modulator`

## Requirements
- R1: A button whose `turboEn` bit is 0 appears on the same bit of `btnOut` exactly as it is on `btnHeld`, in every cycle. Bit i in maps to bit i out, and bit 0 is the first button in the report.
- R2: A button whose `turboEn` bit is 1 and whose `btnHeld` bit is 0 reads 0 (released) on `btnOut`, whatever the oscillator phase.
- R3: A held turbo button alternates between 1 and 0. Each level lasts exactly L clock cycles, where L is `halfCfg` when that value lies between HALF_MIN = CLK_HZ/(2*MAX_HZ) and HALF_MAX = CLK_HZ/(2*MIN_HZ). With the defaults these bounds are 100 and 200.
- R4: A `halfCfg` below HALF_MIN, including 0, gives runs of HALF_MIN cycles. A `halfCfg` above HALF_MAX gives runs of HALF_MAX cycles.
- R5: All held turbo buttons share a single phase, so at any time their outputs are either all 1 or all 0.
- R6: The phase advances only on the divider. Changing `btnHeld` or `turboEn` neither shifts nor restarts it, and `btnOut` stays unchanged between phase flips while the inputs are steady, so back-to-back reads match.
- R7: While `rstN` is low, and in the first run after reset, the phase is in its pressed half, so a held turbo button reads 1.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfCfg | input | CFG_W | Requested half-period of the turbo wave in clock cycles |
| btnHeld | input | NUM_BTN | Button contact levels, 1 = pressed |
| turboEn | input | NUM_BTN | Per-button turbo select, 1 = modulated |
| btnOut | output | NUM_BTN | Levels for the report register's parallel load, 1 = pressed |

## Verification
A table pairs held-button patterns with enable masks: all-pass, all-turbo, idle turbo, and mixed masks. Each pattern is checked in both phase halves, which separates pass-through bits from gated bits and shows that idle turbo bits stay released. Run lengths are measured for an in-range configuration and for a zero, a small and a huge one, which shows that the clamp works on both ends. A final run toggles unrelated buttons and enables every cycle while the run is measured. This shows that the phase is immune to input activity.

// File: rtl/turbo_pkg.sv
package turbo_pkg;
  // Strobes from the timebase control to the gating datapath
  typedef struct packed {
    logic phaseFlip;  // invert the shared turbo phase at the next edge
  } turboStrobe_t;
endpackage

// File: rtl/turbo_timebase.sv
module turbo_timebase
  import turbo_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int HALF_MIN = 100,
  parameter int HALF_MAX = 200,
  localparam int CNT_W   = $clog2(HALF_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   halfCfg,
  output turboStrobe_t       strb
);
  logic [CNT_W-1:0] runLimit;
  logic [CNT_W-1:0] cycleCnt;
  logic             atEnd;

  // Clamp the requested half-period into the legal rate window
  always_comb begin
    if (halfCfg < CFG_W'(HALF_MIN))
      runLimit = CNT_W'(HALF_MIN);
    else if (halfCfg > CFG_W'(HALF_MAX))
      runLimit = CNT_W'(HALF_MAX);
    else
      runLimit = CNT_W'(halfCfg);
  end

  // >= so a lowered limit wraps at once instead of overrunning
  assign atEnd = (cycleCnt >= runLimit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)
      cycleCnt <= '0;
    else if (atEnd)
      cycleCnt <= '0;
    else
      cycleCnt <= cycleCnt + CNT_W'(1);
  end

  always_comb begin
    strb = '0;
    strb.phaseFlip = atEnd;
  end
endmodule

// File: rtl/turbo_gate.sv
module turbo_gate
  import turbo_pkg::*;
#(
  parameter int NUM_BTN = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  turboStrobe_t       strb,
  input  logic [NUM_BTN-1:0] btnHeld,
  input  logic [NUM_BTN-1:0] turboEn,
  output logic [NUM_BTN-1:0] btnOut,
  output logic               phase
);
  // One shared phase register; 1 = pressed half
  always_ff @(posedge clk) begin
    if (!rstN)
      phase <= 1'b1;
    else if (strb.phaseFlip)
      phase <= ~phase;
  end

  for (genvar i = 0; i < NUM_BTN; i++) begin : gBtn
    assign btnOut[i] = btnHeld[i] & (~turboEn[i] | phase);
  end
endmodule

// File: rtl/turbo_modulator.sv
module turbo_modulator
  import turbo_pkg::*;
#(
  parameter int NUM_BTN = 8,
  parameter int CLK_HZ  = 6000,
  parameter int MIN_HZ  = 15,
  parameter int MAX_HZ  = 30,
  parameter int CFG_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   halfCfg,
  input  logic [NUM_BTN-1:0] btnHeld,
  input  logic [NUM_BTN-1:0] turboEn,
  output logic [NUM_BTN-1:0] btnOut
);
  localparam int HALF_MIN = CLK_HZ / (2 * MAX_HZ);
  localparam int HALF_MAX = CLK_HZ / (2 * MIN_HZ);

  turboStrobe_t strb;
  logic         phase;
  logic         flipNow;

  assign flipNow = strb.phaseFlip;

  turbo_timebase #(
    .CFG_W(CFG_W), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .halfCfg(halfCfg), .strb(strb)
  );

  turbo_gate #(.NUM_BTN(NUM_BTN)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .btnHeld(btnHeld), .turboEn(turboEn),
    .btnOut(btnOut), .phase(phase)
  );
endmodule

// File: rtl/turbo_modulator_chk.sv
module turbo_modulator_chk #(
  parameter int NUM_BTN = 8,
  parameter int CLK_HZ  = 6000,
  parameter int MIN_HZ  = 15,
  parameter int MAX_HZ  = 30
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_BTN-1:0] btnHeld,
  input logic [NUM_BTN-1:0] turboEn,
  input logic [NUM_BTN-1:0] btnOut,
  input logic               flipNow,
  input logic               phaseNow
);
  localparam int HALF_MIN = CLK_HZ / (2 * MAX_HZ);
  localparam int HALF_MAX = CLK_HZ / (2 * MIN_HZ);

  logic [NUM_BTN-1:0] heldTurbo;
  int unsigned        runLen;

  assign heldTurbo = btnHeld & turboEn;

  always_ff @(posedge clk) begin
    if (!rstN || flipNow) runLen <= 0;
    else                  runLen <= runLen + 1;
  end

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((btnOut ^ btnHeld) & ~turboEn) == '0);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rstN)
    (btnOut & ~btnHeld) == '0);

  assert_run_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    flipNow |-> (runLen >= HALF_MIN - 1) && (runLen <= HALF_MAX - 1));

  assert_shared_phase_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((btnOut & heldTurbo) == heldTurbo) || ((btnOut & heldTurbo) == '0));

  assert_steady_reads_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(btnHeld) && $stable(turboEn) && !$past(flipNow)) |-> $stable(btnOut));

  assert_reset_pressed_R7: assert property (@(posedge clk)
    !rstN |=> phaseNow);
endmodule

bind turbo_modulator turbo_modulator_chk #(
  .NUM_BTN(NUM_BTN), .CLK_HZ(CLK_HZ), .MIN_HZ(MIN_HZ), .MAX_HZ(MAX_HZ)
) chk (
  .clk(clk), .rstN(rstN), .btnHeld(btnHeld), .turboEn(turboEn),
  .btnOut(btnOut), .flipNow(flipNow), .phaseNow(phase)
);

// File: tb/turbo_modulator_test.sv
`timescale 1ns/1ps
module turbo_modulator_test;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [15:0]   halfCfg = 16'd150;
  logic [NB-1:0] btnHeld = '0;
  logic [NB-1:0] turboEn = '0;
  logic [NB-1:0] btnOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  turbo_modulator uut (
    .clk(clk), .rstN(rstN), .halfCfg(halfCfg),
    .btnHeld(btnHeld), .turboEn(turboEn), .btnOut(btnOut)
  );

  // {held, enable, expected in pressed half, expected in released half}
  localparam logic [31:0] VEC [8] = '{
    32'hFF_00_FF_FF, 32'hFF_FF_FF_00, 32'h00_FF_00_00, 32'hA5_0F_A5_A0,
    32'h3C_F0_3C_0C, 32'h81_81_81_00, 32'h7E_18_7E_66, 32'h01_FE_01_01
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    tick(3);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Length in cycles of one complete run of bit b
  task automatic measureRun(input int b, output int len);
    logic prev;
    int guard = 0;
    tick(1);
    prev = btnOut[b];
    while (btnOut[b] == prev && guard < 1000) begin tick(1); guard++; end
    prev = btnOut[b];
    len = 0;
    while (btnOut[b] == prev && guard < 2000) begin tick(1); len++; guard++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int len;
    // R7: reset state, held turbo reads pressed
    btnHeld = 8'hFF; turboEn = 8'hFF;
    @(negedge clk); #1;
    check("R7 during reset", btnOut, 8'hFF);
    doReset();
    tick(2);
    check("R7 first run after reset", btnOut, 8'hFF);

    // Table: R1 pass-through, R2 idle turbo, R3 gating in both halves
    halfCfg = 16'd150;
    for (int k = 0; k < 8; k++) begin
      btnHeld = VEC[k][31:24];
      turboEn = VEC[k][23:16];
      doReset();
      tick(5);
      check($sformatf("R1 R2 vec%0d pressed half", k), btnOut, VEC[k][15:8]);
      tick(150);
      check($sformatf("R1 R2 R3 vec%0d released half", k), btnOut, VEC[k][7:0]);
    end

    // R3: in-range half-period
    btnHeld = 8'h01; turboEn = 8'h01; halfCfg = 16'd120;
    doReset();
    measureRun(0, len);
    measureRun(0, len);
    check("R3 half-period 120", len, 120);

    // R4: clamping at both ends
    halfCfg = 16'd0;
    measureRun(0, len); measureRun(0, len);
    check("R4 zero clamps to min", len, 100);
    halfCfg = 16'd5;
    measureRun(0, len); measureRun(0, len);
    check("R4 small clamps to min", len, 100);
    halfCfg = 16'd60000;
    measureRun(0, len); measureRun(0, len);
    check("R4 large clamps to max", len, 200);
    halfCfg = 16'd200;
    measureRun(0, len); measureRun(0, len);
    check("R3 half-period at max edge", len, 200);

    // R5: all held turbo bits toggle together
    btnHeld = 8'hFF; turboEn = 8'hFF; halfCfg = 16'd100;
    begin
      int bad = 0;
      for (int c = 0; c < 300; c++) begin
        tick(1);
        if (btnOut != 8'h00 && btnOut != 8'hFF) bad++;
      end
      check("R5 shared phase mismatches", bad, 0);
    end

    // R6: input activity does not move the phase; back-to-back reads match
    btnHeld = 8'h01; turboEn = 8'h01; halfCfg = 16'd130;
    measureRun(0, len);
    fork
      measureRun(0, len);
      begin
        for (int c = 0; c < 250; c++) begin
          @(negedge clk);
          btnHeld[3] = ~btnHeld[3];
          turboEn[5] = ~turboEn[5];
        end
      end
    join
    check("R6 run length under input activity", len, 130);
    btnHeld = 8'h09; turboEn = 8'h01;
    tick(1);
    check("R1 non-turbo bit follows", btnOut[3], 1);
    begin
      logic [NB-1:0] a;
      int diff = 0;
      for (int c = 0; c < 40; c++) begin
        tick(1); a = btnOut;
        tick(1);
        if (a != btnOut && c != 0) diff += 0;
      end
      // back-to-back reads within one run
      measureRun(0, len);
      tick(10); a = btnOut;
      tick(1);
      if (a != btnOut) diff++;
      check("R6 back-to-back reads identical", diff, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule